// File: doc/BRIEF.md
# Bus-Mapped Parallel I/O Controller

This block is a register-mapped digital I/O controller with eight byte-wide ports and eight interrupt input lines. A simple synchronous bus slave interface reaches it: an 8-bit offset, write and read strobes, write data and registered read data. Each port has its own data latch. A shared direction byte chooses, one bit per port, whether the port drives its latch onto the pins or is sampled as an input. Changing a port's direction never alters its latch. A port that is turned to output drives the value that was already stored there.

Each interrupt line passes through a two-flop synchronizer and a rising-edge detector into a sticky flag. Software reads the flags as one read-only byte. Software clears chosen flags by writing ones to a separate offset. The flags show captured edges, not the live level of the lines. An asynchronous active-low system reset puts the block in its initial state. A software-commanded soft reset does the same for the direction byte, the data latches and the interrupt flags.

Top module: `pio_ctrl`

## Requirements
- R1: Bit n of the direction byte (read and written at offset 0x87) drives `port_oe_o[n]`. A 1 makes port n an output. For example, writing 0x90 enables ports 4 and 7 only.
- R2: After system reset, the direction byte, every data latch, every interrupt flag and `rdata_o` are all zero.
- R3: Writing 0x01 to offset 0x88 clears the direction byte, all data latches and all interrupt flags on the clock edge after the write. The outputs keep their values in the cycle right after the write. Any other value written to 0x88 has no effect.
- R4: Writing the direction byte leaves every data latch unchanged. A port switched from input back to output drives and reads back its earlier latch value.
- R5: A write to offset n (0x00 to 0x07) loads port n's data latch. Port n's latch is always present on `port_out_o[8n+7:8n]`. A read of an output port returns its latch.
- R6: A read of port n while it is an input returns `port_in_i[8n+7:8n]` as seen through a two-flop synchronizer.
- R7: A rising edge on synchronized interrupt line n sets bit n of the read-only flag byte at offset 0x80. The bit stays set after the line falls.
- R8: Writing to offset 0x81 clears each flag whose write-data bit is 1 and leaves the others alone. A new edge that lands in the same cycle as its clear leaves the flag set.
- R9: `rdata_o` carries the addressed value in the cycle after `rd_i` is sampled high, and is zero otherwise. Unmapped offsets read as zero. Writes to 0x80 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| addr_i | input | 8 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| port_in_i | input | 64 | Pin levels, port n at bits 8n+7:8n |
| port_out_o | output | 64 | Data latches, port n at bits 8n+7:8n |
| port_oe_o | output | 8 | Output enable per port |
| irq_i | input | 8 | Interrupt input lines |

## Verification
The bound checker watches five behaviours on every cycle. The output enables change only on a direction write or a soft reset. The latches change only on a port write or a soft reset, so a direction write leaves them alone. A soft reset pulse empties the direction, latch and flag state. A flag never falls except through a clear or a soft reset, and a detected edge always lands in its flag. Read data is zero whenever no read was issued. Some behaviours can only be shown by the bench's scenarios: the synchronizer latency on input reads, a flag that survives a clear issued in the exact cycle of its edge, the one-cycle delay of the soft reset and the rejection of a wrong soft-reset key, and readback of a latch after a direction round trip.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t OFS_PORT_BASE = 8'h00;
  localparam addr_t OFS_IRQ_STAT  = 8'h80;
  localparam addr_t OFS_IRQ_CLR   = 8'h81;
  localparam addr_t OFS_DIR       = 8'h87;
  localparam addr_t OFS_SOFT_RST  = 8'h88;
  localparam data_t SOFT_RST_KEY  = 8'h01;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pio_irq_capture.sv
module pio_irq_capture #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] clr_i,
  input  logic         soft_clr_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] sync_lvl;
  logic [N-1:0] prev_q;
  logic [N-1:0] flag_q;

  pio_sync #(.W(N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (sync_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_lvl;
  end

  assign rise_o = sync_lvl & ~prev_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q[i] <= 1'b0;
      else if (soft_clr_i)  flag_q[i] <= 1'b0;
      else if (rise_o[i])   flag_q[i] <= 1'b1;  // new edge beats clear
      else if (clr_i[i])    flag_q[i] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/pio_port_bank.sv
module pio_port_bank #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        soft_clr_i,
  input  logic [NUM_PORTS-1:0]        latch_we_i,
  input  logic [PORT_W-1:0]           wdata_i,
  input  logic                        dir_we_i,
  input  logic [NUM_PORTS-1:0]        dir_wdata_i,
  output logic [NUM_PORTS*PORT_W-1:0] latch_o,
  output logic [NUM_PORTS-1:0]        dir_o
);
  logic [NUM_PORTS-1:0] dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dir_q <= '0;
    else if (soft_clr_i) dir_q <= '0;
    else if (dir_we_i)   dir_q <= dir_wdata_i;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] latch_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            latch_q <= '0;
      else if (soft_clr_i)    latch_q <= '0;
      else if (latch_we_i[p]) latch_q <= wdata_i;
    end
    assign latch_o[p*PORT_W +: PORT_W] = latch_q;
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_IRQ   = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_i,
  input  logic                        rd_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic [NUM_PORTS*DATA_W-1:0] port_in_i,
  output logic [NUM_PORTS*DATA_W-1:0] port_out_o,
  output logic [NUM_PORTS-1:0]        port_oe_o,
  input  logic [NUM_IRQ-1:0]          irq_i
);
  localparam int PW = DATA_W;

  logic                    soft_q;
  logic [NUM_PORTS-1:0]    latch_we;
  logic                    dir_we;
  logic [NUM_PORTS-1:0]    dir;
  logic [NUM_PORTS*PW-1:0] latches;
  logic [NUM_PORTS*PW-1:0] pin_sync;
  logic [NUM_IRQ-1:0]      irq_clr;
  logic [NUM_IRQ-1:0]      irq_flags;
  logic [NUM_IRQ-1:0]      irq_rise;
  logic [DATA_W-1:0]       rd_val;

  // write decode
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++)
      latch_we[p] = wr_i && (addr_i == OFS_PORT_BASE + addr_t'(p));
  end
  assign dir_we  = wr_i && (addr_i == OFS_DIR);
  assign irq_clr = (wr_i && addr_i == OFS_IRQ_CLR) ? wdata_i[NUM_IRQ-1:0] : '0;

  // soft reset: one-cycle pulse, applied on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_q <= 1'b0;
    else         soft_q <= wr_i && (addr_i == OFS_SOFT_RST) && (wdata_i == SOFT_RST_KEY);
  end

  pio_port_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_q),
    .latch_we_i (latch_we),
    .wdata_i    (wdata_i),
    .dir_we_i   (dir_we),
    .dir_wdata_i(wdata_i[NUM_PORTS-1:0]),
    .latch_o    (latches),
    .dir_o      (dir)
  );

  pio_sync #(.W(NUM_PORTS*PW)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_in_i),
    .q_o   (pin_sync)
  );

  pio_irq_capture #(.N(NUM_IRQ)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (irq_i),
    .clr_i     (irq_clr),
    .soft_clr_i(soft_q),
    .flags_o   (irq_flags),
    .rise_o    (irq_rise)
  );

  // read mux
  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (addr_i == OFS_PORT_BASE + addr_t'(p))
        rd_val = dir[p] ? latches[p*PW +: PW] : pin_sync[p*PW +: PW];
    if (addr_i == OFS_IRQ_STAT) rd_val = DATA_W'(irq_flags);
    if (addr_i == OFS_DIR)      rd_val = DATA_W'(dir);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
    else           rdata_o <= '0;
  end

  assign port_out_o = latches;
  assign port_oe_o  = dir;
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk
  import pio_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_IRQ   = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [ADDR_W-1:0]           addr_i,
  input logic                        wr_i,
  input logic                        rd_i,
  input logic [DATA_W-1:0]           rdata_o,
  input logic [NUM_PORTS*DATA_W-1:0] port_out_o,
  input logic [NUM_PORTS-1:0]        port_oe_o,
  input logic                        soft_q,
  input logic [NUM_IRQ-1:0]          irq_flags,
  input logic [NUM_IRQ-1:0]          irq_rise
);
  localparam addr_t PORT_END = OFS_PORT_BASE + addr_t'(NUM_PORTS);

  logic port_wr;
  assign port_wr = wr_i && (addr_i >= OFS_PORT_BASE) && (addr_i < PORT_END);

  // R1
  oe_only_on_dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i && addr_i == OFS_DIR) && !soft_q) |=> $stable(port_oe_o));

  // R4
  latch_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_wr && !soft_q) |=> $stable(port_out_o));

  // R3
  soft_clears_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_q |=> (port_oe_o == '0 && port_out_o == '0 && irq_flags == '0));

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_q && !(wr_i && addr_i == OFS_IRQ_CLR))
      |=> ((irq_flags & $past(irq_flags)) == $past(irq_flags)));

  // R8
  edge_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_q |=> ((irq_flags & $past(irq_rise)) == $past(irq_rise)));

  // R9
  idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
endmodule

bind pio_ctrl pio_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .port_out_o(port_out_o),
  .port_oe_o (port_oe_o),
  .soft_q    (soft_q),
  .irq_flags (irq_flags),
  .irq_rise  (irq_rise)
);

// File: tb/pio_ctrl_bench.sv
module pio_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [63:0] port_in_i = '0;
  logic [63:0] port_out_o;
  logic [7:0]  port_oe_o;
  logic [7:0]  irq_i = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk_i = ~clk_i;  // 125 MHz

  pio_ctrl u_pio_ctrl (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .port_in_i, .port_out_o, .port_oe_o, .irq_i
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      bit seen;
      @(posedge clk_i);
      seen = rd_i;
      @(negedge clk_i);
      if (seen) begin
        if (exp_q.size() == 0) check("R9 unexpected read", 1, 0);
        else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    check("R2 oe reset", port_oe_o, 8'h00);
    check("R2 latches reset", port_out_o, 64'h0);
    check("R2 rdata reset", rdata_o, 8'h00);
    bus_rd(8'h87, 8'h00, "R2 dir reset");
    bus_rd(8'h80, 8'h00, "R2 flags reset");

    // latch and direction
    bus_wr(8'h03, 8'h5A);
    check("R5 latch on pins", port_out_o[24 +: 8], 8'h5A);
    bus_wr(8'h87, 8'h08);
    check("R1 oe port3", port_oe_o, 8'h08);
    bus_rd(8'h03, 8'h5A, "R5 output readback");
    bus_wr(8'h87, 8'h90);
    check("R1 oe ports 4,7", port_oe_o, 8'h90);
    bus_rd(8'h87, 8'h90, "R1 dir readback");
    check("R4 latch kept on dir write", port_out_o[24 +: 8], 8'h5A);
    port_in_i[24 +: 8] = 8'hC3;
    idle(3);
    bus_rd(8'h03, 8'hC3, "R6 input pin read");
    bus_wr(8'h87, 8'h08);
    bus_rd(8'h03, 8'h5A, "R4 latch after round trip");
    bus_wr(8'h06, 8'hE7);
    bus_rd(8'h06, 8'h00, "R6 input port reads pins");
    check("R5 port6 latch", port_out_o[48 +: 8], 8'hE7);

    // interrupts
    irq_i = 8'h24;
    idle(4);
    irq_i = 8'h00;
    idle(4);
    bus_rd(8'h80, 8'h24, "R7 sticky flags");
    bus_wr(8'h81, 8'h04);
    bus_rd(8'h80, 8'h20, "R8 selective clear");
    bus_wr(8'h80, 8'hFF);
    bus_rd(8'h80, 8'h20, "R9 status write ignored");
    bus_rd(8'h40, 8'h00, "R9 unmapped read");

    // soft reset
    bus_wr(8'h88, 8'h02);
    idle(2);
    check("R3 wrong key oe", port_oe_o, 8'h08);
    check("R3 wrong key latch", port_out_o[24 +: 8], 8'h5A);
    bus_wr(8'h88, 8'h01);
    check("R3 not yet applied", port_oe_o, 8'h08);
    idle(1);
    check("R3 oe cleared", port_oe_o, 8'h00);
    check("R3 latches cleared", port_out_o, 64'h0);
    bus_rd(8'h80, 8'h00, "R3 flags cleared");

    // edge and clear in the same cycle
    @(negedge clk_i);
    irq_i[1] = 1'b1;
    @(posedge clk_i);
    @(posedge clk_i);
    bus_wr(8'h81, 8'h02);
    bus_rd(8'h80, 8'h02, "R8 edge beats clear");
    irq_i[1] = 1'b0;
    bus_wr(8'h81, 8'h02);
    bus_rd(8'h80, 8'h00, "R8 later clear");

    idle(3);
    check("R9 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule